// File: doc/BRIEF.md
# Runahead Mode Controller with Checkpointed Register File

This block holds the architectural registers of a single-thread in-order core and keeps that thread useful while a blocking load miss is outstanding. When the miss is reported, the whole register file is copied into a shadow bank in one clock and the block enters a speculative runahead mode. The same thread keeps issuing. Every register carries a poison bit. Results that depend on the missing data become poisoned. Clean results commit at once. Loads with a clean address that miss in the cache produce a prefetch request, so several misses can be outstanding together.

When the fill for the original miss comes back, the block restores in a single cycle. Registers last written by clean, retired runahead instructions keep their new values. Every other register takes its shadow value. The block then returns to normal mode. Decode, the ALUs and the cache sit outside the block. The issue port carries the instruction's register indices, an opcode, a precomputed result and a cache-hit flag.

Top module: `runahead_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the mode at normal, clears every poison bit and the prefetch count to zero, and clears every register and shadow entry to zero.
- R2: In normal mode an issued instruction with opcode 2'b00 (ALU) or 2'b01 (load) writes its result into register `iss_rd`. Opcodes 2'b10 and 2'b11 write nothing. The read port returns the register value combinationally.
- R3: A miss-start in normal mode copies all registers into the shadow bank on that clock edge. It sets the mode to runahead, poisons register `miss_dst` and clears the prefetch count to zero.
- R4: In runahead mode, an ALU instruction, or a load with `iss_hit`=1, whose sources are not poisoned writes its destination, clears that register's poison bit, and keeps the value across the restore. An ALU instruction reads `iss_rs1` and `iss_rs2`. A load reads only `iss_rs1`.
- R5: In runahead mode an instruction with a poisoned source does not write its destination. It poisons that register, and the restore returns the register to its shadow value.
- R6: In runahead mode a load with a clean address register and `iss_hit`=0 raises `pf_valid` in the same cycle, with `pf_addr` equal to the value of `iss_rs1`. It adds one to the prefetch count and poisons its destination.
- R7: A runahead load whose address register is poisoned raises no prefetch and leaves the count unchanged.
- R8: A miss-start while already in runahead mode takes no new snapshot. It adds one to the prefetch count and poisons `miss_dst`.
- R9: A fill-return in runahead mode restores the registers in one cycle, sets the mode to normal and clears all poison bits. A fill-return in normal mode has no effect.
- R10: The prefetch count saturates at 2^PF_CW-1. Its value persists after the return to normal mode until the next entry into runahead mode.
- R11: `mode` reads 1'b0 in normal mode and 1'b1 in runahead mode. `pf_valid` is never high in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_start | input | 1 | Blocking load miss reported |
| miss_dst | input | AW | Destination register of the missing load |
| fill_done | input | 1 | Data of the blocking miss returned |
| iss_valid | input | 1 | Instruction issued this cycle |
| iss_op | input | 2 | Opcode: 00 ALU, 01 load, others none |
| iss_rd | input | AW | Destination register |
| iss_rs1 | input | AW | First source (load address) |
| iss_rs2 | input | AW | Second source (ALU only) |
| iss_result | input | DW | Result from the stubbed datapath |
| iss_hit | input | 1 | Load hit in cache |
| rd_idx | input | AW | Read port index |
| rd_data | output | DW | Read port data |
| rd_poison | output | 1 | Poison bit of the read register |
| mode | output | 1 | 0 normal, 1 runahead |
| pf_valid | output | 1 | Prefetch request this cycle |
| pf_addr | output | DW | Prefetch address |
| pf_count | output | PF_CW | Prefetches in the current or last episode |

## Verification
The hardest case to reach is a register that a clean runahead instruction rewrites and a poisoned one later overwrites, after a second miss-start has arrived. Only a correct restore returns that register to its value from before runahead. A stray second snapshot returns the speculative value instead. The stimulus table builds exactly that chain: r6 commits 0x0066, a second miss arrives, then r6 is poisoned. The test also chains loads through poisoned address registers to confirm that no prefetch comes out. Directed tests then drive the prefetch count past saturation and assert reset in the middle of an episode.

// File: rtl/ra_pkg.sv
package ra_pkg;
   typedef enum logic [1:0] {
      OP_ALU  = 2'b00,
      OP_LOAD = 2'b01,
      OP_NONE = 2'b10,
      OP_RSVD = 2'b11
   } ra_op_e;

   typedef enum logic {
      MODE_NORMAL   = 1'b0,
      MODE_RUNAHEAD = 1'b1
   } ra_mode_e;
endpackage

// File: rtl/ra_mode_ctl.sv
module ra_mode_ctl
   import ra_pkg::*;
#(
   parameter int PF_CW = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             miss_start,
   input  logic             fill_done,
   input  logic             pf_fire,
   output logic             mode_run,
   output logic             enter,
   output logic             restore,
   output logic             extra_miss,
   output logic [PF_CW-1:0] pf_cnt
);
   localparam logic [PF_CW-1:0] CNT_MAX = '1;

   ra_mode_e         mode_q;
   logic [PF_CW-1:0] cnt_q, cnt_d;
   logic [1:0]       inc;
   logic [PF_CW:0]   sum;

   assign mode_run   = (mode_q == MODE_RUNAHEAD);
   assign enter      = miss_start && !mode_run;
   assign restore    = fill_done && mode_run;
   assign extra_miss = miss_start && mode_run && !fill_done;

   always_comb begin
      inc = {1'b0, pf_fire} + {1'b0, extra_miss};
      sum = {1'b0, cnt_q} + (PF_CW+1)'(inc);
      cnt_d = (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[PF_CW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_NORMAL;
         cnt_q  <= '0;
      end else if (enter) begin
         mode_q <= MODE_RUNAHEAD;
         cnt_q  <= '0;
      end else if (restore) begin
         mode_q <= MODE_NORMAL;
      end else if (mode_run) begin
         cnt_q  <= cnt_d;
      end
   end

   assign pf_cnt = cnt_q;

   // R10
   cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_run && !restore) |=> (cnt_q >= $past(cnt_q)));

   // R9
   idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_run && !miss_start) |=> $stable(cnt_q));
endmodule

// File: rtl/ra_poison_trk.sv
module ra_poison_trk #(
   parameter int NREG = 8,
   parameter int AW   = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mode_run,
   input  logic            enter,
   input  logic            restore,
   input  logic            extra_miss,
   input  logic [AW-1:0]   miss_dst,
   input  logic            wr_valid,
   input  logic            wr_poison,
   input  logic [AW-1:0]   wr_rd,
   input  logic [AW-1:0]   rs1,
   input  logic [AW-1:0]   rs2,
   input  logic            use_rs2,
   input  logic [AW-1:0]   rd_idx,
   output logic            src_poison,
   output logic            rd_poison,
   output logic [NREG-1:0] keep_mask
);
   logic [NREG-1:0] poison_q;
   logic [NREG-1:0] keep_q;

   for (genvar i = 0; i < NREG; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst || restore) begin
            poison_q[i] <= 1'b0;
            keep_q[i]   <= 1'b0;
         end else if (enter) begin
            poison_q[i] <= (miss_dst == AW'(i));
            keep_q[i]   <= 1'b0;
         end else if (wr_valid && wr_rd == AW'(i)) begin
            poison_q[i] <= wr_poison;
            keep_q[i]   <= !wr_poison;
         end else if (extra_miss && miss_dst == AW'(i)) begin
            poison_q[i] <= 1'b1;
            keep_q[i]   <= 1'b0;
         end
      end
   end

   assign src_poison = mode_run && (poison_q[rs1] || (use_rs2 && poison_q[rs2]));
   assign rd_poison  = poison_q[rd_idx];
   assign keep_mask  = keep_q;

   // R9
   poison_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !mode_run |-> (poison_q == '0));

   // R4
   keep_clean_chk: assert property (@(posedge clk) disable iff (rst)
      (keep_q & poison_q) == '0);
endmodule

// File: rtl/ra_regfile_ckpt.sv
module ra_regfile_ckpt #(
   parameter int NREG      = 8,
   parameter int DW        = 16,
   parameter int AW        = $clog2(NREG),
   parameter bit CLR_DATA  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            snap,
   input  logic            restore,
   input  logic [NREG-1:0] keep_mask,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [DW-1:0]   wd,
   input  logic [AW-1:0]   rs1,
   input  logic [AW-1:0]   rd_idx,
   output logic [DW-1:0]   rs1_val,
   output logic [DW-1:0]   rd_data
);
   logic [DW-1:0] regs_q [NREG];
   logic [DW-1:0] ckpt_q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] nxt;
      always_comb begin
         nxt = regs_q[i];
         if (restore) begin
            if (!keep_mask[i]) nxt = ckpt_q[i];
         end else if (we && wa == AW'(i)) begin
            nxt = wd;
         end
      end

      if (CLR_DATA) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst) begin
               regs_q[i] <= '0;
               ckpt_q[i] <= '0;
            end else begin
               regs_q[i] <= nxt;
               if (snap) ckpt_q[i] <= regs_q[i];
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            regs_q[i] <= nxt;
            if (snap) ckpt_q[i] <= regs_q[i];
         end
      end
   end

   assign rs1_val = regs_q[rs1];
   assign rd_data = regs_q[rd_idx];

   // R8
   ckpt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !snap |=> (ckpt_q[0] == $past(ckpt_q[0])));

   // R5
   restore_lane0_chk: assert property (@(posedge clk) disable iff (rst)
      (restore && !keep_mask[0]) |=> (regs_q[0] == $past(ckpt_q[0])));
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
   import ra_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int DW    = 16,
   parameter int PF_CW = 3,
   parameter int AW    = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             miss_start,
   input  logic [AW-1:0]    miss_dst,
   input  logic             fill_done,
   input  logic             iss_valid,
   input  logic [1:0]       iss_op,
   input  logic [AW-1:0]    iss_rd,
   input  logic [AW-1:0]    iss_rs1,
   input  logic [AW-1:0]    iss_rs2,
   input  logic [DW-1:0]    iss_result,
   input  logic             iss_hit,
   input  logic [AW-1:0]    rd_idx,
   output logic [DW-1:0]    rd_data,
   output logic             rd_poison,
   output logic             mode,
   output logic             pf_valid,
   output logic [DW-1:0]    pf_addr,
   output logic [PF_CW-1:0] pf_count
);
   if (NREG < 2 || NREG > 64) begin : g_bad_nreg
      $error("runahead_ctrl: NREG out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("runahead_ctrl: DW must be positive");
   end
   if (PF_CW < 1 || PF_CW > 16) begin : g_bad_cw
      $error("runahead_ctrl: PF_CW out of range");
   end

   logic            mode_run, enter, restore, extra_miss;
   logic            src_poison, pf_fire;
   logic            is_alu, is_load, is_op;
   logic            ra_act, nm_act, ra_commit;
   logic [NREG-1:0] keep_mask;
   logic [DW-1:0]   rs1_val;

   assign is_alu  = (iss_op == OP_ALU);
   assign is_load = (iss_op == OP_LOAD);
   assign is_op   = is_alu || is_load;

   assign ra_act    = mode_run && iss_valid && is_op && !restore;
   assign nm_act    = !mode_run && iss_valid && is_op && !miss_start;
   assign pf_fire   = ra_act && is_load && !iss_hit && !src_poison;
   assign ra_commit = ra_act && !src_poison && !(is_load && !iss_hit);

   ra_mode_ctl #(.PF_CW(PF_CW)) u_mode (
      .clk        (clk),
      .rst        (rst),
      .miss_start (miss_start),
      .fill_done  (fill_done),
      .pf_fire    (pf_fire),
      .mode_run   (mode_run),
      .enter      (enter),
      .restore    (restore),
      .extra_miss (extra_miss),
      .pf_cnt     (pf_count)
   );

   ra_poison_trk #(.NREG(NREG), .AW(AW)) u_poison (
      .clk        (clk),
      .rst        (rst),
      .mode_run   (mode_run),
      .enter      (enter),
      .restore    (restore),
      .extra_miss (extra_miss),
      .miss_dst   (miss_dst),
      .wr_valid   (ra_act),
      .wr_poison  (!ra_commit),
      .wr_rd      (iss_rd),
      .rs1        (iss_rs1),
      .rs2        (iss_rs2),
      .use_rs2    (is_alu),
      .rd_idx     (rd_idx),
      .src_poison (src_poison),
      .rd_poison  (rd_poison),
      .keep_mask  (keep_mask)
   );

   ra_regfile_ckpt #(.NREG(NREG), .DW(DW), .AW(AW), .CLR_DATA(1'b1)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .snap      (enter),
      .restore   (restore),
      .keep_mask (keep_mask),
      .we        (nm_act || ra_commit),
      .wa        (iss_rd),
      .wd        (iss_result),
      .rs1       (iss_rs1),
      .rd_idx    (rd_idx),
      .rs1_val   (rs1_val),
      .rd_data   (rd_data)
   );

   assign mode     = mode_run;
   assign pf_valid = pf_fire;
   assign pf_addr  = rs1_val;

   // R11
   pf_normal_chk: assert property (@(posedge clk) disable iff (rst)
      pf_valid |-> mode);

   // R7
   pf_poison_chk: assert property (@(posedge clk) disable iff (rst)
      src_poison |-> !pf_valid);

   // R9
   fill_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (mode && fill_done) |=> !mode);

   // R3
   enter_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode && miss_start) |=> (mode && pf_count == '0));
endmodule

// File: tb/runahead_ctrl_tb_top.sv
module runahead_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int DW = 16;
   localparam int PF_CW = 3;
   localparam int AW = 3;
   localparam int NVEC = 17;

   typedef struct packed {
      logic          miss;
      logic [2:0]    dst;
      logic          fill;
      logic          iv;
      logic [1:0]    op;
      logic [2:0]    rd;
      logic [2:0]    rs1;
      logic [2:0]    rs2;
      logic [15:0]   res;
      logic          hit;
      logic          epfv;
      logic [15:0]   epfa;
      logic          emode;
      logic [2:0]    ecnt;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd1,3'd0,3'd0,16'h0010,1'b0,1'b0,16'h0,1'b0,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd2,3'd0,3'd0,16'h0020,1'b0,1'b0,16'h0,1'b0,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd3,3'd0,3'd0,16'h0030,1'b0,1'b0,16'h0,1'b0,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd4,3'd1,3'd0,16'h0040,1'b1,1'b0,16'h0,1'b0,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd5,3'd0,3'd0,16'h0050,1'b0,1'b0,16'h0,1'b0,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd7,3'd0,3'd0,16'h0070,1'b0,1'b0,16'h0,1'b0,3'd0},
      '{1'b1,3'd5,1'b0,1'b0,2'd2,3'd0,3'd0,3'd0,16'h0000,1'b0,1'b0,16'h0,1'b1,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd6,3'd1,3'd2,16'h0066,1'b0,1'b0,16'h0,1'b1,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd3,3'd5,3'd1,16'hBEEF,1'b0,1'b0,16'h0,1'b1,3'd0},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd7,3'd2,3'd0,16'h0000,1'b0,1'b1,16'h0020,1'b1,3'd1},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd4,3'd7,3'd0,16'h0000,1'b0,1'b0,16'h0,1'b1,3'd1},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd2,3'd1,3'd0,16'h0222,1'b1,1'b0,16'h0,1'b1,3'd1},
      '{1'b1,3'd0,1'b0,1'b0,2'd2,3'd0,3'd0,3'd0,16'h0000,1'b0,1'b0,16'h0,1'b1,3'd2},
      '{1'b0,3'd0,1'b0,1'b1,2'd0,3'd6,3'd5,3'd1,16'h0BAD,1'b0,1'b0,16'h0,1'b1,3'd2},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd1,3'd6,3'd0,16'h0000,1'b0,1'b0,16'h0,1'b1,3'd2},
      '{1'b0,3'd0,1'b0,1'b1,2'd1,3'd0,3'd2,3'd0,16'h0000,1'b0,1'b1,16'h0222,1'b1,3'd3},
      '{1'b0,3'd0,1'b1,1'b0,2'd2,3'd0,3'd0,3'd0,16'h0000,1'b0,1'b0,16'h0,1'b0,3'd3}
   };

   logic             clk = 1'b0;
   logic             rst;
   logic             miss_start, fill_done, iss_valid, iss_hit;
   logic [AW-1:0]    miss_dst, iss_rd, iss_rs1, iss_rs2, rd_idx;
   logic [1:0]       iss_op;
   logic [DW-1:0]    iss_result, rd_data, pf_addr;
   logic             rd_poison, mode, pf_valid;
   logic [PF_CW-1:0] pf_count;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   runahead_ctrl #(.NREG(NREG), .DW(DW), .PF_CW(PF_CW)) dut_i (
      .clk(clk), .rst(rst), .miss_start(miss_start), .miss_dst(miss_dst),
      .fill_done(fill_done), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
      .iss_result(iss_result), .iss_hit(iss_hit), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_poison(rd_poison), .mode(mode),
      .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_count(pf_count)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      miss_start = 1'b0; miss_dst = '0; fill_done = 1'b0; iss_valid = 1'b0;
      iss_op = 2'd2; iss_rd = '0; iss_rs1 = '0; iss_rs2 = '0;
      iss_result = '0; iss_hit = 1'b0;
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      miss_start = v.miss; miss_dst = v.dst; fill_done = v.fill;
      iss_valid = v.iv; iss_op = v.op; iss_rd = v.rd; iss_rs1 = v.rs1;
      iss_rs2 = v.rs2; iss_result = v.res; iss_hit = v.hit;
      #1;
   endtask

   task automatic read_reg(input logic [AW-1:0] idx, input logic [DW-1:0] exp,
                           input logic exp_p, input string tag);
      rd_idx = idx;
      #1;
      chk(tag, 32'(rd_data), 32'(exp));
      chk(tag, 32'(rd_poison), 32'(exp_p));
   endtask

   function automatic vec_t runahead_load_miss(input logic [2:0] rd, input logic [2:0] rs1);
      vec_t v;
      v = '0;
      v.iv = 1'b1; v.op = 2'd1; v.rd = rd; v.rs1 = rs1;
      return v;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] exp_rf [NREG];
      vec_t v;
      idle_inputs();
      rd_idx = '0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk("R1 mode", 32'(mode), 32'(0));
      chk("R1 count", 32'(pf_count), 32'(0));
      chk("R1 pf_valid", 32'(pf_valid), 32'(0));
      read_reg(3'd3, 16'h0, 1'b0, "R1 reg");

      for (int k = 0; k < NVEC; k++) begin
         if (k == 6) begin
            // R2: normal writes visible before runahead
            read_reg(3'd4, 16'h0040, 1'b0, "R2 load write");
            read_reg(3'd7, 16'h0070, 1'b0, "R2 alu write");
         end
         apply(VEC[k]);
         // R6 R7 R11: combinational prefetch request
         chk($sformatf("R6 R7 R11 pf_valid row %0d", k), 32'(pf_valid), 32'(VEC[k].epfv));
         if (VEC[k].epfv)
            chk($sformatf("R6 pf_addr row %0d", k), 32'(pf_addr), 32'(VEC[k].epfa));
         @(posedge clk);
         #1;
         // R3 R8 R9 R11: mode and count after the edge
         chk($sformatf("R3 R8 R9 mode row %0d", k), 32'(mode), 32'(VEC[k].emode));
         chk($sformatf("R3 R6 R8 count row %0d", k), 32'(pf_count), 32'(VEC[k].ecnt));
         idle_inputs();
         if (k == 8) begin
            read_reg(3'd3, 16'h0030, 1'b1, "R5 poisoned dst not written");
            read_reg(3'd6, 16'h0066, 1'b0, "R4 clean commit");
         end
      end

      // R4 R5 R8 R9: register file after restore
      exp_rf = '{16'h0000, 16'h0010, 16'h0222, 16'h0030,
                 16'h0040, 16'h0050, 16'h0000, 16'h0070};
      for (int r = 0; r < NREG; r++)
         read_reg(AW'(r), exp_rf[r], 1'b0, $sformatf("R4 R5 R8 R9 restore r%0d", r));

      // R9: fill in normal mode ignored
      v = '0; v.fill = 1'b1;
      apply(v);
      @(posedge clk); #1;
      idle_inputs();
      chk("R9 idle fill mode", 32'(mode), 32'(0));
      read_reg(3'd2, 16'h0222, 1'b0, "R9 idle fill reg");

      // R3: new episode clears count and poisons miss_dst
      v = '0; v.miss = 1'b1; v.dst = 3'd3;
      apply(v);
      @(posedge clk); #1;
      idle_inputs();
      chk("R3 reentry count", 32'(pf_count), 32'(0));
      read_reg(3'd3, 16'h0030, 1'b1, "R3 miss dst poisoned");
      read_reg(3'd2, 16'h0222, 1'b0, "R3 other clean");

      // R10: saturation
      for (int n = 1; n <= 9; n++) begin
         apply(runahead_load_miss(3'd7, 3'd2));
         chk("R10 pf during sat", 32'(pf_valid), 32'(1));
         @(posedge clk); #1;
         idle_inputs();
         chk($sformatf("R10 count step %0d", n), 32'(pf_count), 32'((n > 7) ? 7 : n));
      end

      // R1: reset in runahead
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      chk("R1 reset mode", 32'(mode), 32'(0));
      chk("R1 reset count", 32'(pf_count), 32'(0));
      read_reg(3'd3, 16'h0, 1'b0, "R1 reset poison and data");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule